// File: doc/BRIEF.md
# Dual Palette Lookup Table

This block keeps two independent colour palettes of 256 entries each, used by a pixel path to turn an 8-bit colour index into a 24-bit RGB value. Software loads a palette sequentially: it writes a start index to the table's address register, then streams colour words into that table's data register. Each stored word advances the table's write pointer by one entry.

Every stored entry needs a settling period before the table accepts the next write. During that period the table raises its own busy flag, and any write aimed at it is dropped. A load that runs past the last entry is refused rather than wrapped. The refused write raises a sticky overflow flag for that table only.

On the pixel side, an index and a table select are presented every cycle. The selected table's entry appears on the colour output one clock later.

Top module: `dual_palette_lut`

## Requirements
- R1: After reset, both busy flags and both overflow flags are low.
- R2: A write with `cfg_data_sel`=0 sets the addressed table's write pointer to `cfg_wdata[7:0]`; bits [31:8] have no effect.
- R3: Each accepted write with `cfg_data_sel`=1 stores `cfg_wdata[23:0]` at the current pointer and advances the pointer by one; bits [31:24] are not stored.
- R4: `cfg_tsel` (0 = table 0, 1 = table 1) picks the table; a write to one table never changes the other table's entries, pointer, busy or overflow state.
- R5: A stored data write holds that table's busy flag high for exactly SETTLE_CYC cycles, starting in the cycle after the write.
- R6: Any write, address or data, to a table whose busy flag is high is dropped: no entry, pointer or flag of that table changes.
- R7: Once entry 255 has been stored, further data writes to that table store nothing, do not wrap to entry 0, do not raise busy, and set that table's overflow flag.
- R8: The overflow flag stays high until reset; a later address write re-arms loading from the new index without clearing the flag.
- R9: `pix_rgb` shows the entry at `pix_idx` of the table chosen by `pix_tsel` (0 = table 0) one clock after they are presented.
- R10: A pixel read of the entry being written in the same cycle returns the entry's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_tsel | input | 1 | Target table of the write |
| cfg_data_sel | input | 1 | 0 = address register, 1 = data register |
| cfg_wdata | input | 32 | Write data |
| tbl_busy | output | 2 | Per-table settling flag |
| tbl_ovf | output | 2 | Per-table sticky overflow flag |
| pix_tsel | input | 1 | Table feeding the pixel read |
| pix_idx | input | 8 | Pixel colour index |
| pix_rgb | output | 24 | Colour read, one cycle latency |

## Verification
The bench keeps the full 8-bit index width, so every entry of both tables is loaded and read back in one sweep. Both the natural end of a load at entry 255 and the refused write after it are therefore reached directly. SETTLE_CYC is lowered to 2, which keeps the 512 paced writes short. It also leaves a narrow busy window, so the dropped-write cases can be placed on a known cycle. The stored pattern is a closed-form function of table and index, with junk in the ignored upper bits.

// File: rtl/dpl_pkg.sv
package dpl_pkg;
  typedef enum logic {
    CFG_ADDR = 1'b0,
    CFG_DATA = 1'b1
  } cfg_kind_e;
endpackage

// File: rtl/dpl_loader.sv
module dpl_loader
  import dpl_pkg::*;
#(
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned COLOR_W    = 24,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  cfg_kind_e          wr_kind,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               mem_we,
  output logic [IDX_W-1:0]   mem_addr,
  output logic [COLOR_W-1:0] mem_wdata,
  output logic               busy,
  output logic               ovf
);
  localparam int unsigned CNT_W = (SETTLE_CYC > 0) ? $clog2(SETTLE_CYC + 1) : 1;
  localparam logic [IDX_W-1:0] LAST = '1;
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC);

  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             take, set_addr, put_data;

  always_comb begin
    busy     = (cnt_q != '0);
    take     = wr_en && !busy;
    set_addr = take && (wr_kind == CFG_ADDR);
    put_data = take && (wr_kind == CFG_DATA);
    mem_we   = put_data && !done_q;
    mem_addr = ptr_q;
    mem_wdata = wr_data[COLOR_W-1:0];

    ptr_d  = ptr_q;
    done_d = done_q;
    ovf_d  = ovf_q;
    cnt_d  = busy ? (cnt_q - 1'b1) : '0;

    if (set_addr) begin
      ptr_d  = wr_data[IDX_W-1:0];
      done_d = 1'b0;
    end
    if (mem_we) begin
      cnt_d = SETTLE_LD;
      if (ptr_q == LAST) done_d = 1'b1;
      else               ptr_d  = ptr_q + 1'b1;
    end
    if (put_data && done_q) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
    end
  end

  assign ovf = ovf_q;

  // R3
  ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && ptr_q != LAST) |=> (ptr_q == $past(ptr_q) + 1'b1));

  // R7
  last_entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && ptr_q == LAST) |=> (ptr_q == LAST && done_q));

  // R7
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(wr_en && wr_kind == CFG_DATA && done_q));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> ($stable(ptr_q) && $stable(done_q) && $stable(ovf_q)));

  if (SETTLE_CYC > 0) begin : g_busy_chk
    // R5
    busy_after_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> busy);
  end
endmodule

// File: rtl/dpl_bank.sv
module dpl_bank #(
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned COLOR_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IDX_W-1:0]   waddr,
  input  logic [COLOR_W-1:0] wdata,
  input  logic [IDX_W-1:0]   raddr,
  output logic [COLOR_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [COLOR_W-1:0] mem [DEPTH];
  logic [COLOR_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= mem[raddr];
  end

  assign rdata = rd_q;
endmodule

// File: rtl/dual_palette_lut.sv
module dual_palette_lut
  import dpl_pkg::*;
#(
  parameter int unsigned NUM_TABLES = 2,
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned COLOR_W    = 24,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SETTLE_CYC = 4,
  localparam int unsigned TSEL_W    = (NUM_TABLES > 1) ? $clog2(NUM_TABLES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [TSEL_W-1:0]     cfg_tsel,
  input  logic                  cfg_data_sel,
  input  logic [DATA_W-1:0]     cfg_wdata,
  output logic [NUM_TABLES-1:0] tbl_busy,
  output logic [NUM_TABLES-1:0] tbl_ovf,
  input  logic [TSEL_W-1:0]     pix_tsel,
  input  logic [IDX_W-1:0]      pix_idx,
  output logic [COLOR_W-1:0]    pix_rgb
);
  logic [COLOR_W-1:0] rd_data [NUM_TABLES];
  logic [TSEL_W-1:0]  sel_q;
  cfg_kind_e          kind;

  assign kind = cfg_kind_e'(cfg_data_sel);

  for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tbl
    logic               we;
    logic [IDX_W-1:0]   waddr;
    logic [COLOR_W-1:0] wdata;
    logic               sel_hit;

    assign sel_hit = cfg_we && (cfg_tsel == TSEL_W'(t));

    dpl_loader #(
      .IDX_W(IDX_W), .COLOR_W(COLOR_W), .DATA_W(DATA_W), .SETTLE_CYC(SETTLE_CYC)
    ) u_loader (
      .clk(clk), .rst_n(rst_n), .wr_en(sel_hit), .wr_kind(kind), .wr_data(cfg_wdata),
      .mem_we(we), .mem_addr(waddr), .mem_wdata(wdata),
      .busy(tbl_busy[t]), .ovf(tbl_ovf[t])
    );

    dpl_bank #(.IDX_W(IDX_W), .COLOR_W(COLOR_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
      .raddr(pix_idx), .rdata(rd_data[t])
    );

    // R4
    other_table_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_tsel != TSEL_W'(t) && !tbl_busy[t]) |=> !$rose(tbl_busy[t]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= pix_tsel;
  end

  assign pix_rgb = rd_data[sel_q];
endmodule

// File: tb/dual_palette_lut_tb.sv
`timescale 1ns/1ps
module dual_palette_lut_tb;
  localparam int SETTLE = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_tsel, cfg_data_sel;
  logic [31:0] cfg_wdata;
  logic [1:0]  tbl_busy, tbl_ovf;
  logic        pix_tsel;
  logic [7:0]  pix_idx;
  logic [23:0] pix_rgb;

  int n_chk = 0;
  int n_fail = 0;
  bit reported = 0;
  logic [23:0] exp_mem [2][256];

  always #4 clk = ~clk;

  dual_palette_lut #(.SETTLE_CYC(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tsel(cfg_tsel),
    .cfg_data_sel(cfg_data_sel), .cfg_wdata(cfg_wdata), .tbl_busy(tbl_busy),
    .tbl_ovf(tbl_ovf), .pix_tsel(pix_tsel), .pix_idx(pix_idx), .pix_rgb(pix_rgb)
  );

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(int t, int i, int r);
    logic [23:0] c;
    c = 24'(i * 24'h010203 + t * 24'h800000 + r * 24'h0F0F0F);
    return {8'(8'hA5 ^ i), c};
  endfunction

  task automatic wr(bit t, bit dat, logic [31:0] d);
    cfg_we = 1'b1; cfg_tsel = t; cfg_data_sel = dat; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle(bit t);
    while (tbl_busy[t]) @(negedge clk);
  endtask

  task automatic rd(string req, bit t, int idx);
    pix_tsel = t; pix_idx = 8'(idx);
    @(negedge clk);
    chk(req, {8'h0, pix_rgb}, {8'h0, exp_mem[t][idx]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int cnt;
    logic [23:0] old;
    rst_n = 1'b0; cfg_we = 0; cfg_tsel = 0; cfg_data_sel = 0; cfg_wdata = '0;
    pix_tsel = 0; pix_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 busy", {30'h0, tbl_busy}, 32'h0);
    chk("R1 ovf", {30'h0, tbl_ovf}, 32'h0);

    // R2 R3 R5: full load of both tables, upper address bits junk
    for (int t = 0; t < 2; t++) begin
      wr(t[0], 1'b0, 32'hFFFF_FF00);
      for (int i = 0; i < 256; i++) begin
        wr(t[0], 1'b1, pat(t, i, 0));
        exp_mem[t][i] = pat(t, i, 0) & 24'hFFFFFF;
        cnt = 0;
        while (tbl_busy[t]) begin cnt++; @(negedge clk); end
        chk("R5 busy length", cnt, SETTLE);
      end
    end
    chk("R7 no ovf at exact end", {30'h0, tbl_ovf}, 32'h0);

    // R3 R4 R9: read sweep alternating tables every cycle
    for (int i = 0; i < 256; i++)
      for (int t = 0; t < 2; t++) rd("R9 sweep", t[0], i);

    // R6: writes to a busy table are dropped
    wr(1'b0, 1'b0, 32'd10);
    wr(1'b0, 1'b1, 32'hEE11_2233);        // stored at 10
    exp_mem[0][10] = 24'h112233;
    wr(1'b0, 1'b1, 32'h0044_5566);        // busy -> dropped
    wr(1'b0, 1'b0, 32'd200);              // busy -> dropped
    wait_idle(1'b0);
    wr(1'b0, 1'b1, 32'h0077_8899);        // lands at 11
    exp_mem[0][11] = 24'h778899;
    wait_idle(1'b0);
    rd("R6 first", 1'b0, 10);
    rd("R6 pointer kept", 1'b0, 11);
    rd("R6 neighbour", 1'b0, 12);
    rd("R6 dropped addr", 1'b0, 200);

    // R4: other table accepts writes while this one is busy
    wr(1'b0, 1'b0, 32'd50);
    wr(1'b0, 1'b1, 32'h00AB_CDEF);
    exp_mem[0][50] = 24'hABCDEF;
    wr(1'b1, 1'b0, 32'd60);
    wr(1'b1, 1'b1, 32'h0012_3456);
    exp_mem[1][60] = 24'h123456;
    wait_idle(1'b0); wait_idle(1'b1);
    rd("R4 t0", 1'b0, 50);
    rd("R4 t1", 1'b1, 60);
    rd("R4 t1 untouched", 1'b1, 50);
    rd("R4 t0 untouched", 1'b0, 60);
    rd("R4 t0 next", 1'b0, 51);

    // R7: overflow at end of table 1
    wr(1'b1, 1'b0, 32'd254);
    wr(1'b1, 1'b1, 32'h00CA_FE01); exp_mem[1][254] = 24'hCAFE01; wait_idle(1'b1);
    wr(1'b1, 1'b1, 32'h00CA_FE02); exp_mem[1][255] = 24'hCAFE02; wait_idle(1'b1);
    chk("R7 ovf before", {31'h0, tbl_ovf[1]}, 32'h0);
    wr(1'b1, 1'b1, 32'h00DE_AD00);
    chk("R7 ovf set", {31'h0, tbl_ovf[1]}, 32'h1);
    chk("R7 no busy", {31'h0, tbl_busy[1]}, 32'h0);
    chk("R4 other ovf", {31'h0, tbl_ovf[0]}, 32'h0);
    rd("R7 last kept", 1'b1, 255);
    rd("R7 no wrap", 1'b1, 0);
    rd("R7 other table", 1'b0, 0);

    // R8: sticky flag, address write re-arms
    wr(1'b1, 1'b0, 32'd5);
    chk("R8 still set", {31'h0, tbl_ovf[1]}, 32'h1);
    wr(1'b1, 1'b1, 32'h0055_AA55); exp_mem[1][5] = 24'h55AA55;
    chk("R8 busy on reload", {31'h0, tbl_busy[1]}, 32'h1);
    wait_idle(1'b1);
    chk("R8 still set after", {31'h0, tbl_ovf[1]}, 32'h1);
    rd("R8 reload", 1'b1, 5);

    // R10: read during write returns old contents
    wr(1'b0, 1'b0, 32'd7);
    old = exp_mem[0][7];
    pix_tsel = 1'b0; pix_idx = 8'd7;
    wr(1'b0, 1'b1, 32'h0013_5791);
    chk("R10 old value", {8'h0, pix_rgb}, {8'h0, old});
    exp_mem[0][7] = 24'h135791;
    rd("R10 new value", 1'b0, 7);

    // R9: select switch with same index
    rd("R9 switch t1", 1'b1, 7);
    rd("R9 switch t0", 1'b0, 7);

    report();
  end
endmodule